// File: doc/BRIEF.md
# Static memory bus controller

This block connects an internal request port to an asynchronous external parallel memory bus that has six chip selects. A requester presents a read or a write together with a chip-select index, a word address and write data, holds the request until the block pulses ready for one cycle, and then takes the read data and an error flag. On the bus side the block drives active-low chip-select, output-enable, write-enable and address-valid strobes. It also drives the address and a data bus that is split into output, output-enable and input signals.

Every chip select has two timing words that are loaded through a simple write port, plus one bit in a common enable mask. The "slow" word holds the read and write wait states, the initial latencies for the first access within a page, the write hold and the bus-turnaround recovery. The "fast" word holds the read hold, the spacing from address-valid to output-enable, and an address-hold flag. The block tracks the last page and direction used on each chip select, and the direction and chip select of the last access. From these it decides when to add the first-access latency and when to add recovery cycles.

Top module: `asram_bus_ctrl`

## Requirements
- R1: After reset the block is in this state:
  - every strobe is high and the data bus output enable is low;
  - ready is low;
  - every timing word and every enable bit is zero;
  - there is no pending recovery and no page history.
  
  A first read on a chip select enabled after reset therefore has one active cycle and a total latency of 3.
- R2: A request to a disabled chip select, or to an index of 6 or 7, returns ready with error set in the cycle after it is accepted. It asserts no strobe, returns read data zero, and changes neither the recovery state nor the page state.
- R3: On a read, output-enable stays low for (slow[3:0]+1) cycles, plus the first-access latency when that latency applies. The read data returned is the bus input sampled in the last of those cycles.
- R4: On a write, write-enable stays low for (slow[7:4]+1) cycles, plus the first-access latency when that latency applies. The data output carries the request's write data throughout that time.
- R5: The first-access latency adds slow[15:8] cycles to a read and slow[23:16] cycles to a write. It applies when any of these holds:
  - the chip select has no earlier access since reset;
  - the page, which is address bits [AW-1:4], differs from the last access on that chip select;
  - the direction differs from the last access on that chip select.
- R6: After write-enable rises, the chip select stays low and the data output enable stays high for slow[27:24] further cycles.
- R7: The block inserts (slow[31:28]+1) idle cycles before the address phase when the previous completed access was a read and either the new access uses another chip select or is a write. The field comes from the chip select of that previous read. No idle cycles are inserted in any other case.
- R8: On a read, output-enable falls (fast[27:24] + fast[17:16]) cycles after the address-valid cycle, counted after the address-hold cycle when one is present. On a write, write-enable follows the address phase at once.
- R9: When fast bit 5 is set, one extra cycle with chip select low and address-valid high follows the address-valid cycle.
- R10: Address-valid is low for exactly one cycle, the first cycle of the access, with exactly one chip select low. The address stays stable for as long as the chip select is low.
- R11: Ready is a one-cycle pulse. The time from accepting a request to ready equals the number of recovery cycles plus the number of chip-select-low cycles, and ready comes in the cycle after that. The chip select that is driven low is the one the request names.
- R12: The data output enable is high only during write-enable and write-hold cycles. It is never high while output-enable is low, and output-enable and write-enable are never low together.
- R13: A configuration write selects its target with cfg_sel and cfg_idx:
  - cfg_sel 0 stores the slow word for chip select cfg_idx;
  - cfg_sel 1 stores the fast word for chip select cfg_idx;
  - cfg_sel 2 loads the enable mask from cfg_wdata[5:0], where bit i enables chip select i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 slow word, 1 fast word, 2 enable mask |
| cfg_idx | input | 3 | Chip select addressed by a timing-word write |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present, held until ready |
| req_write | input | 1 | 1 write, 0 read |
| req_cs | input | 3 | Chip-select index |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | DW | Read data, valid with ready |
| req_err | output | 1 | Error flag, valid with ready |
| bus_cs_n | output | NCS | Active-low chip selects |
| bus_oe_n | output | 1 | Active-low output enable |
| bus_we_n | output | 1 | Active-low write enable |
| bus_adv_n | output | 1 | Active-low address valid |
| bus_addr | output | AW | Bus address |
| bus_dq_out | output | DW | Data bus output value |
| bus_dq_oe | output | 1 | Data bus output enable |
| bus_dq_in | input | DW | Data bus input value |

## Verification
The requests are arranged in patterns that separate behaviours which are otherwise easy to confuse:
- Read pairs within one page, across the boundary between addresses 0x1F and 0x20, and with the direction flipped separate page and direction tracking from a plain wait count.
- Read-to-read on the same chip select, read to another chip select, read-to-write, and write-to-read show which transitions insert recovery, and chip selects programmed with different recovery fields show whose field is used.
- Chip selects with only the address-to-output-enable spacing, only the address hold, or maximum waits and hold distinguish the offset of the output-enable edge from the overall length.
- Requests to a disabled chip select and to out-of-range indices, each followed by a normal access, show that errors leave the bus and the tracking state untouched.

// File: rtl/asram_bus_ctrl.sv
`timescale 1ns/1ps
module asram_bus_ctrl #(
  parameter int NCS = 6,
  parameter int AW = 20,
  parameter int DW = 32,
  parameter int PGW = 4,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) + ((2**$clog2(NCS) == NCS) ? 1 : 0) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_sel,
  input  logic [CSW-1:0] cfg_idx,
  input  logic [31:0]    cfg_wdata,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [CSW-1:0] req_cs,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           req_ready,
  output logic [DW-1:0]  req_rdata,
  output logic           req_err,
  output logic [NCS-1:0] bus_cs_n,
  output logic           bus_oe_n,
  output logic           bus_we_n,
  output logic           bus_adv_n,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_dq_out,
  output logic           bus_dq_oe,
  input  logic [DW-1:0]  bus_dq_in
);
  localparam int CNTW = $clog2(255 + 16 + 18 + 1);
  localparam int PGN = AW - PGW;

  typedef enum logic [2:0] {S_IDLE, S_REC, S_ADV, S_AHLD, S_SETUP, S_ACT, S_WHLD, S_DONE} st_t;

  st_t             st;
  logic [31:0]     slow_q [NCS];
  logic [6:0]      fast_q [NCS];
  logic [PGN-1:0]  pg_q [NCS];
  logic [NCS-1:0]  en_q, pv_q, pd_q;
  logic            rdl_q, wr_q, first_q, err_q;
  logic [CSW-1:0]  lcs_q, cs_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q, rdata_q;
  logic [CNTW-1:0] cnt;

  wire hit       = (int'(req_cs) < NCS) && en_q[req_cs];
  wire req_first = !pv_q[req_cs] || (pg_q[req_cs] != req_addr[AW-1:PGW]) || (pd_q[req_cs] != req_write);
  wire need_rec  = rdl_q && ((lcs_q != req_cs) || req_write);

  wire [31:0] sl = slow_q[cs_q];
  wire [6:0]  fs = fast_q[cs_q];

  wire [CNTW-1:0] setup_n = CNTW'(fs[6:3]) + CNTW'(fs[2:1]);
  wire [CNTW-1:0] act_n   = CNTW'(first_q ? (wr_q ? sl[23:16] : sl[15:8]) : 8'd0)
                          + CNTW'(wr_q ? sl[7:4] : sl[3:0]) + CNTW'(1);
  wire [CNTW-1:0] hold_n  = CNTW'(sl[27:24]);
  wire            use_setup = !wr_q && (setup_n != '0);
  wire st_t       post_st   = use_setup ? S_SETUP : S_ACT;
  wire [CNTW-1:0] post_cnt  = use_setup ? setup_n - CNTW'(1) : act_n - CNTW'(1);

  wire busy = (st == S_ADV) || (st == S_AHLD) || (st == S_SETUP) || (st == S_ACT) || (st == S_WHLD);

  assign bus_cs_n   = busy ? ~(NCS'(1) << cs_q) : '1;
  assign bus_adv_n  = (st != S_ADV);
  assign bus_oe_n   = !((st == S_ACT) && !wr_q);
  assign bus_we_n   = !((st == S_ACT) && wr_q);
  assign bus_dq_oe  = wr_q && ((st == S_ACT) || (st == S_WHLD));
  assign bus_dq_out = wdata_q;
  assign bus_addr   = addr_q;
  assign req_ready  = (st == S_DONE);
  assign req_rdata  = rdata_q;
  assign req_err    = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCS; i++) begin
        slow_q[i] <= '0;
        fast_q[i] <= '0;
        pg_q[i]   <= '0;
      end
      en_q <= '0; pv_q <= '0; pd_q <= '0;
      rdl_q <= 1'b0; lcs_q <= '0;
      wr_q <= 1'b0; first_q <= 1'b0; err_q <= 1'b0; cs_q <= '0;
      addr_q <= '0; wdata_q <= '0; rdata_q <= '0;
      cnt <= '0;
      st <= S_IDLE;
    end else begin
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: if (int'(cfg_idx) < NCS) slow_q[cfg_idx] <= cfg_wdata;
          2'd1: if (int'(cfg_idx) < NCS) fast_q[cfg_idx] <= {cfg_wdata[27:24], cfg_wdata[17:16], cfg_wdata[5]};
          2'd2: en_q <= cfg_wdata[NCS-1:0];
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (req_valid) begin
          wr_q    <= req_write;
          cs_q    <= req_cs;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          rdata_q <= '0;
          err_q   <= !hit;
          if (!hit) st <= S_DONE;
          else begin
            first_q         <= req_first;
            pv_q[req_cs]    <= 1'b1;
            pd_q[req_cs]    <= req_write;
            pg_q[req_cs]    <= req_addr[AW-1:PGW];
            rdl_q           <= !req_write;
            lcs_q           <= req_cs;
            if (need_rec) begin
              st  <= S_REC;
              cnt <= CNTW'(slow_q[lcs_q][31:28]);
            end else st <= S_ADV;
          end
        end
        S_REC: if (cnt == '0) st <= S_ADV; else cnt <= cnt - CNTW'(1);
        S_ADV: if (fs[0]) st <= S_AHLD;
               else begin st <= post_st; cnt <= post_cnt; end
        S_AHLD: begin st <= post_st; cnt <= post_cnt; end
        S_SETUP: if (cnt == '0) begin st <= S_ACT; cnt <= act_n - CNTW'(1); end
                 else cnt <= cnt - CNTW'(1);
        S_ACT: if (cnt == '0) begin
          if (!wr_q) rdata_q <= bus_dq_in;
          if (wr_q && (hold_n != '0)) begin st <= S_WHLD; cnt <= hold_n - CNTW'(1); end
          else st <= S_DONE;
        end else cnt <= cnt - CNTW'(1);
        S_WHLD: if (cnt == '0) st <= S_DONE; else cnt <= cnt - CNTW'(1);
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/asram_bus_chk.sv
`timescale 1ns/1ps
module asram_bus_chk #(
  parameter int NCS = 6,
  parameter int AW = 20
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCS-1:0] cs_n,
  input logic           oe_n,
  input logic           we_n,
  input logic           adv_n,
  input logic           dq_oe,
  input logic [AW-1:0]  addr,
  input logic           ready,
  input logic           err
);
  // R10
  adv_one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_n |-> ($countones(~cs_n) == 1));
  // R10
  adv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_n |=> adv_n);
  // R10
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cs_n != '1) && ($past(cs_n) == cs_n)) |-> $stable(addr));
  // R12
  no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (oe_n && (cs_n != '1)));
  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> we_n);
  // R11
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  // R2
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && err) |-> ((&cs_n) && $past(&cs_n)));
endmodule

bind asram_bus_ctrl asram_bus_chk #(.NCS(NCS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(bus_cs_n), .oe_n(bus_oe_n), .we_n(bus_we_n),
  .adv_n(bus_adv_n), .dq_oe(bus_dq_oe), .addr(bus_addr), .ready(req_ready), .err(req_err)
);

// File: tb/asram_bus_ctrl_bench.sv
`timescale 1ns/1ps
module asram_bus_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [2:0] cfg_idx = 0; logic [31:0] cfg_wdata = 0;
  logic req_valid = 0, req_write = 0; logic [2:0] req_cs = 0;
  logic [19:0] req_addr = 0; logic [31:0] req_wdata = 0;
  logic req_ready, req_err; logic [31:0] req_rdata;
  logic [5:0] bus_cs_n; logic bus_oe_n, bus_we_n, bus_adv_n, bus_dq_oe;
  logic [19:0] bus_addr; logic [31:0] bus_dq_out, bus_dq_in;

  always #2.5 clk = ~clk;
  assign bus_dq_in = 32'h5A00_0000 ^ 32'(bus_addr);

  asram_bus_ctrl u_asram_bus_ctrl (.*);

  typedef struct {
    int lat, ncs, noe, nwe, ndq, nadv, ofs;
    bit err; logic [31:0] rdata, wd; logic [5:0] csm;
  } item_t;
  item_t q[$];
  string tq[$];
  int nchk = 0, nfail = 0;

  logic [31:0] m_slow [6], m_fast [6];
  logic [5:0] m_en = 0;
  bit m_pv [6], m_pd [6]; int m_pg [6];
  bit m_rdl = 0; int m_lcs = 0;

  task automatic chk(string tag, string what, longint a, longint e);
    nchk++;
    if (a != e) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, a, e);
    end
  endtask

  task automatic cfg(int sel, int idx, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_idx = 3'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (sel == 0) m_slow[idx] = d;
    else if (sel == 1) m_fast[idx] = d;
    else m_en = d[5:0];
  endtask

  task automatic do_req(bit w, int cs, int addr, logic [31:0] wd, string tag);
    item_t it;
    int rec, ah, setup, act, whold, pg; bit first;
    logic [31:0] sl, fs;
    it.wd = wd;
    if (cs > 5 || !m_en[cs]) begin
      it.lat = 1; it.ncs = 0; it.noe = 0; it.nwe = 0; it.ndq = 0; it.nadv = 0;
      it.ofs = -1; it.err = 1; it.rdata = 0; it.csm = '1;
    end else begin
      rec = (m_rdl && (m_lcs != cs || w)) ? int'(m_slow[m_lcs][31:28]) + 1 : 0;
      pg = addr >> 4;
      first = !m_pv[cs] || m_pg[cs] != pg || m_pd[cs] != w;
      m_pv[cs] = 1; m_pg[cs] = pg; m_pd[cs] = w; m_rdl = !w; m_lcs = cs;
      sl = m_slow[cs]; fs = m_fast[cs];
      ah = int'(fs[5]);
      setup = w ? 0 : int'(fs[27:24]) + int'(fs[17:16]);
      act = (first ? int'(w ? sl[23:16] : sl[15:8]) : 0) + int'(w ? sl[7:4] : sl[3:0]) + 1;
      whold = w ? int'(sl[27:24]) : 0;
      it.ncs = 1 + ah + setup + act + whold;
      it.lat = rec + it.ncs + 1;
      it.noe = w ? 0 : act; it.nwe = w ? act : 0; it.ndq = w ? act + whold : 0;
      it.nadv = 1; it.ofs = 1 + ah + setup; it.err = 0;
      it.rdata = w ? 32'h0 : (32'h5A00_0000 ^ addr);
      it.csm = ~(6'd1 << cs);
    end
    q.push_back(it); tq.push_back(tag);
    @(negedge clk);
    req_valid = 1; req_write = w; req_cs = 3'(cs); req_addr = 20'(addr); req_wdata = wd;
    do @(negedge clk); while (!req_ready);
    req_valid = 0;
  endtask

  initial begin : monitor
    int lat = 0, noe = 0, nwe = 0, ndq = 0, ncs = 0, nadv = 0, ofs = -1, pos = 0, wbad = 0, csbad = 0;
    bit started = 0;
    item_t e; string t;
    forever begin
      @(posedge clk); #1;
      if (rst_n) begin
        if (req_valid) lat++;
        if (!bus_oe_n) noe++;
        if (!bus_we_n) begin
          nwe++;
          if (q.size() > 0 && bus_dq_out != q[0].wd) wbad++;
        end
        if (bus_dq_oe) ndq++;
        if (bus_cs_n != '1) begin
          ncs++;
          if (q.size() > 0 && bus_cs_n != q[0].csm) csbad++;
        end
        if (!bus_adv_n) begin nadv++; started = 1; pos = 0; end
        if (started && ofs < 0 && (!bus_oe_n || !bus_we_n)) ofs = pos;
        if (started) pos++;
        if (req_ready) begin
          if (q.size() == 0) chk("R11", "spurious ready", 1, 0);
          else begin
            e = q.pop_front(); t = tq.pop_front();
            chk({t, " R11"}, "latency", lat, e.lat);
            chk({t, " R11"}, "cs low cycles", ncs, e.ncs);
            chk({t, " R11"}, "wrong cs cycles", csbad, 0);
            chk({t, " R3"}, "oe low cycles", noe, e.noe);
            chk({t, " R4"}, "we low cycles", nwe, e.nwe);
            chk({t, " R4"}, "wdata mismatches", wbad, 0);
            chk({t, " R6 R12"}, "dq_oe cycles", ndq, e.ndq);
            chk({t, " R10"}, "adv cycles", nadv, e.nadv);
            chk({t, " R8 R9"}, "strobe offset", ofs, e.ofs);
            chk({t, " R2"}, "err", req_err, e.err);
            chk({t, " R3"}, "rdata", req_rdata, e.rdata);
          end
          lat = 0; noe = 0; nwe = 0; ndq = 0; ncs = 0; nadv = 0; ofs = -1; wbad = 0; csbad = 0; started = 0;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R11 watchdog expired: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : stim
    for (int i = 0; i < 6; i++) begin m_slow[i] = 0; m_fast[i] = 0; m_pv[i] = 0; m_pd[i] = 0; m_pg[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "cs_n reset", bus_cs_n, 6'h3F);
    chk("R1", "oe/we/adv reset", {bus_oe_n, bus_we_n, bus_adv_n}, 3'b111);
    chk("R1", "dq_oe reset", bus_dq_oe, 0);
    chk("R1", "ready reset", req_ready, 0);
    do_req(0, 0, 'h10, 0, "R1 R2 disabled-after-reset");
    cfg(2, 0, 32'h0000_001F);
    do_req(0, 5, 'h10, 0, "R2 R13 cs5-disabled");
    do_req(1, 6, 'h10, 32'h1111_1111, "R2 index6");
    do_req(0, 7, 'h10, 0, "R2 index7");
    do_req(0, 0, 'h10, 0, "R1 R3 zero-timing");
    cfg(0, 0, 32'h0000_0700);
    do_req(0, 0, 'h1F, 0, "R5 same-page");
    do_req(0, 0, 'h20, 0, "R5 page-boundary");
    cfg(0, 1, 32'h2305_0423);
    cfg(1, 1, 32'h0201_0020);
    do_req(0, 1, 'h120, 0, "R7 R8 R9 R5 cs-change");
    do_req(0, 1, 'h125, 0, "R3 R7 no-rec");
    do_req(0, 1, 'h130, 0, "R5 new-page");
    do_req(1, 1, 'h131, 32'hDEAD_BEEF, "R4 R6 R7 read-to-write");
    do_req(1, 1, 'h132, 32'h1234_5678, "R4 R6 write-same-page");
    do_req(0, 1, 'h133, 0, "R5 R7 write-to-read");
    cfg(0, 2, 32'h5000_FF0A);
    do_req(1, 2, 'h40, 32'hCAFE_0001, "R7 R4 rec-from-prev-cs");
    do_req(0, 2, 'h41, 0, "R5 R3 max-latency");
    do_req(0, 0, 'h20, 0, "R7 rec6-then-same-page");
    cfg(1, 3, 32'h0003_0000);
    do_req(0, 3, 'h0, 0, "R8 adv-oe-only");
    cfg(0, 4, 32'h0F00_00FF);
    do_req(1, 4, 'h7, 32'h0BAD_F00D, "R4 R6 max-wait-hold");
    do_req(0, 4, 'h7, 0, "R3 max-read-wait");
    cfg(2, 0, 32'h0000_001D);
    do_req(0, 1, 'h125, 0, "R2 R13 disabled-later");
    do_req(0, 0, 'h20, 0, "R2 R7 state-kept");
    repeat (4) @(negedge clk);
    chk("R11", "pending items", q.size(), 0);
    chk("R1", "idle strobes", {bus_cs_n, bus_oe_n, bus_we_n, bus_adv_n, bus_dq_oe}, 10'b1111111110);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule